// File: doc/BRIEF.md
# Line-Blanking Ancillary Byte Inserter

This block sits on an 8-bit multiplexed YCrCb byte stream that carries the four-byte timing codes marking the end and the start of active video. It takes data bytes from a vertical-blanking slicer and writes them into the horizontal blanking gap of the stream. The slicer delivers its bytes in groups, one group for each line it decoded, and it marks the last byte of each group. The inserter holds these groups in a buffer. It writes one whole group into the blanking gap of a later output line, choosing the first line on which insertion is allowed.

A small set of line numbers is closed to insertion, and that set depends on the selected standard. A group that becomes ready while the current line is closed waits for the next open line. On every byte position where nothing is inserted, the stream passes through unchanged after a fixed pipeline delay. Because of this, the timing codes leave the block with the same spacing they had on entry.

Top module: `anc_inserter`

## Requirements
- R1: Every byte that is not replaced by inserted data passes through unchanged. The byte sampled on `vid_in` at rising edge k appears on `vid_out` right after rising edge k+4.
- R2: A timing code is the bytes 0xFF, 0x00, 0x00 followed by a code byte. A code byte with bit 4 set ends active video. Insertion starts on the first byte after that code byte.
- R3: Inserted bytes leave in the same order in which they were written into the queue, and each one replaces one blanking byte (0x80 or 0x10).
- R4: A group fills consecutive blanking positions on a single line. The blanking bytes after its last byte keep their input values.
- R5: A group longer than 84 bytes is cut to its first 84 bytes. The extra bytes are dropped, and `ovf` goes high and stays high until reset.
- R6: With `std625` = 0, no group is started on lines 9, 10, 11, 272, 273 or 274.
- R7: With `std625` = 1, no group is started on lines 5, 6, 7, 318, 319 or 320.
- R8: A group held back by a closed line is written on the next line that is open.
- R9: A group is started only when its last byte (`q_last` = 1) is already in the buffer. A group that is still arriving when a line begins is not placed on that line.
- R10: A timing code whose code byte has bit 4 clear does not start insertion. Timing codes and active-video bytes are never overwritten.
- R11: While `rst` is high, `vid_out` reads 0x00 and `ovf` reads 0.
- R12: At most one group is written per line, even when several complete groups are waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_in | input | 8 | Incoming multiplexed YCrCb byte |
| vid_line | input | LINE_W | Number of the line currently entering |
| std625 | input | 1 | 1 selects the 625-line closed set, 0 the 525-line set |
| q_valid | input | 1 | A slicer byte is present on q_data |
| q_data | input | 8 | Slicer data byte |
| q_last | input | 1 | Marks the final byte of a slicer group |
| vid_out | output | 8 | Outgoing byte stream with inserted data |
| ovf | output | 1 | Sticky flag: a group was cut to 84 bytes |

## Verification
The properties rely on three conditions of the input stream. First, the value 0xFF appears only as the first byte of a timing code. Second, the blanking gap after an end code is longer than 84 bytes. Third, the byte buffer never fills, so that every accepted group is complete. The stimulus builds each line from a fixed layout with 100 blanking bytes, and it keeps active bytes in the range 0x40 to 0x7F. It starts at most one slicer group every three lines, and that pace keeps the queue short. Some of these groups are deliberately written across a line boundary, so that an incomplete group is seen at the start of a line.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam logic [7:0] CODE_LEAD = 8'hFF;
  localparam logic [7:0] CODE_ZERO = 8'h00;
  localparam int         XY_EAV_BIT = 4;

  // closed lines of each standard
  function automatic logic line_closed(input logic [15:0] ln, input logic sel625);
    if (sel625)
      return (ln == 16'd5) || (ln == 16'd6) || (ln == 16'd7) ||
             (ln == 16'd318) || (ln == 16'd319) || (ln == 16'd320);
    else
      return (ln == 16'd9) || (ln == 16'd10) || (ln == 16'd11) ||
             (ln == 16'd272) || (ln == 16'd273) || (ln == 16'd274);
  endfunction
endpackage

// File: rtl/anc_code_det.sv
module anc_code_det #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        vid_in,
  input  logic [LINE_W-1:0] vid_line,
  output logic [7:0]        d_out,
  output logic              tag_out,
  output logic [LINE_W-1:0] line_q
);
  import anc_pkg::*;
  localparam int STAGES = 4;

  logic [7:0]        dl [STAGES];
  logic [STAGES-1:0] tg;
  logic              end_hit;

  // code byte of an end-of-active code sits in dl[0]; the incoming byte is tagged
  assign end_hit = (dl[3] == CODE_LEAD) && (dl[2] == CODE_ZERO) &&
                   (dl[1] == CODE_ZERO) && dl[0][XY_EAV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) dl[i] <= '0;
      tg     <= '0;
      line_q <= '0;
    end else begin
      dl[0] <= vid_in;
      for (int i = 1; i < STAGES; i++) dl[i] <= dl[i-1];
      tg <= {tg[STAGES-2:0], end_hit};
      if (end_hit) line_q <= vid_line;
    end
  end

  assign d_out   = dl[STAGES-1];
  assign tag_out = tg[STAGES-1];
endmodule

// File: rtl/anc_byte_buf.sv
module anc_byte_buf #(
  parameter int DEPTH = 512,
  parameter int GQ    = 16,
  parameter int MAXB  = 84
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_valid,
  input  logic [7:0]                   wr_data,
  input  logic                         wr_last,
  input  logic                         rd_pop,
  input  logic                         grp_pop,
  output logic [7:0]                   rd_data,
  output logic                         grp_avail,
  output logic [$clog2(MAXB+1)-1:0]    grp_len,
  output logic                         buf_empty,
  output logic                         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int GW = $clog2(GQ);
  localparam int LW = $clog2(MAXB+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, rptr_nx;
  logic [AW:0]   fill;
  logic          wr_en;
  logic [LW-1:0] gcnt;
  logic          pend_v;
  logic [LW-1:0] pend_len;

  logic [LW-1:0] lq [GQ];
  logic [GW-1:0] gw, gr;
  logic [GW:0]   gfill;

  assign wr_en   = wr_valid && (gcnt < LW'(MAXB)) && (fill < (AW+1)'(DEPTH));
  assign rptr_nx = rptr + AW'(rd_pop);

  // data storage: synchronous write, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    rd_data <= mem[rptr_nx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      gcnt     <= '0;
      pend_v   <= 1'b0;
      pend_len <= '0;
      ovf      <= 1'b0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      rptr <= rptr_nx;
      fill <= fill + (AW+1)'(wr_en) - (AW+1)'(rd_pop);
      if (wr_valid && !wr_en) ovf <= 1'b1;
      pend_v <= 1'b0;
      if (wr_valid) begin
        if (wr_last) begin
          gcnt     <= '0;
          pend_v   <= 1'b1;
          pend_len <= wr_en ? gcnt + 1'b1 : gcnt;
        end else if (wr_en) begin
          gcnt <= gcnt + 1'b1;
        end
      end
    end
  end

  // group length queue, one cycle behind the last data write
  always_ff @(posedge clk) begin
    if (rst) begin
      gw    <= '0;
      gr    <= '0;
      gfill <= '0;
    end else begin
      if (pend_v) begin
        lq[gw] <= pend_len;
        gw     <= gw + 1'b1;
      end
      if (grp_pop) gr <= gr + 1'b1;
      gfill <= gfill + (GW+1)'(pend_v) - (GW+1)'(grp_pop);
    end
  end

  assign grp_avail = (gfill != '0);
  assign grp_len   = lq[gr];
  assign buf_empty = (fill == '0);
endmodule

// File: rtl/anc_inserter.sv
module anc_inserter #(
  parameter int LINE_W = 10,
  parameter int DEPTH  = 512,
  parameter int GQ     = 16,
  parameter int MAXB   = 84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        vid_in,
  input  logic [LINE_W-1:0] vid_line,
  input  logic              std625,
  input  logic              q_valid,
  input  logic [7:0]        q_data,
  input  logic              q_last,
  output logic [7:0]        vid_out,
  output logic              ovf
);
  import anc_pkg::*;
  localparam int LW = $clog2(MAXB+1);

  logic [7:0]        d_late, rd_data;
  logic              first_blank;
  logic [LINE_W-1:0] line_q;
  logic              grp_avail, buf_empty;
  logic [LW-1:0]     grp_len;
  logic              start, ins_use, ins_active, closed;
  logic [LW-1:0]     ins_left;

  anc_code_det #(.LINE_W(LINE_W)) det_i (
    .clk(clk), .rst(rst), .vid_in(vid_in), .vid_line(vid_line),
    .d_out(d_late), .tag_out(first_blank), .line_q(line_q)
  );

  anc_byte_buf #(.DEPTH(DEPTH), .GQ(GQ), .MAXB(MAXB)) buf_i (
    .clk(clk), .rst(rst), .wr_valid(q_valid), .wr_data(q_data), .wr_last(q_last),
    .rd_pop(ins_use), .grp_pop(start), .rd_data(rd_data), .grp_avail(grp_avail),
    .grp_len(grp_len), .buf_empty(buf_empty), .ovf(ovf)
  );

  assign closed  = line_closed(16'(line_q), std625);
  assign start   = first_blank && grp_avail && !closed && !ins_active;
  assign ins_use = start || ins_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_out    <= '0;
      ins_active <= 1'b0;
      ins_left   <= '0;
    end else begin
      vid_out <= ins_use ? rd_data : d_late;
      if (start) begin
        ins_left   <= grp_len - 1'b1;
        ins_active <= (grp_len > LW'(1));
      end else if (ins_active) begin
        ins_left   <= ins_left - 1'b1;
        ins_active <= (ins_left > LW'(1));
      end
    end
  end
endmodule

// File: rtl/anc_inserter_chk.sv
module anc_inserter_chk #(
  parameter int LINE_W = 10,
  parameter int MAXB   = 84
) (
  input logic                      clk,
  input logic                      rst,
  input logic [7:0]                vid_in,
  input logic [7:0]                vid_out,
  input logic                      ovf,
  input logic                      ins_use,
  input logic                      grp_start,
  input logic [$clog2(MAXB+1)-1:0] grp_len,
  input logic                      buf_empty,
  input logic [LINE_W-1:0]         line_q,
  input logic                      std625
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end

  // R1
  p_pass_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6 && !$past(ins_use)) |-> (vid_out == $past(vid_in, 5)));

  // R5
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R5
  p_group_cap_r5: assert property (@(posedge clk) disable iff (rst)
    grp_start |-> (grp_len != '0 && grp_len <= ($clog2(MAXB+1))'(MAXB)));

  // R9
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    ins_use |-> !buf_empty);

  // R6
  p_closed_525_r6: assert property (@(posedge clk) disable iff (rst)
    (grp_start && !std625) |-> !(line_q == 9 || line_q == 10 || line_q == 11 ||
                                 line_q == 272 || line_q == 273 || line_q == 274));

  // R7
  p_closed_625_r7: assert property (@(posedge clk) disable iff (rst)
    (grp_start && std625) |-> !(line_q == 5 || line_q == 6 || line_q == 7 ||
                                line_q == 318 || line_q == 319 || line_q == 320));
endmodule

bind anc_inserter anc_inserter_chk #(.LINE_W(LINE_W), .MAXB(MAXB)) chk_i (
  .clk(clk), .rst(rst), .vid_in(vid_in), .vid_out(vid_out), .ovf(ovf),
  .ins_use(ins_use), .grp_start(start), .grp_len(grp_len), .buf_empty(buf_empty),
  .line_q(line_q), .std625(std625)
);

// File: tb/anc_inserter_tb_top.sv
module anc_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] vid_in;
  logic [9:0] vid_line;
  logic       std625;
  logic       q_valid, q_last;
  logic [7:0] q_data;
  logic [7:0] vid_out;
  logic       ovf;

  always #2 clk = ~clk;

  anc_inserter dut_i (
    .clk(clk), .rst(rst), .vid_in(vid_in), .vid_line(vid_line), .std625(std625),
    .q_valid(q_valid), .q_data(q_data), .q_last(q_last), .vid_out(vid_out), .ovf(ovf)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int pcnt = 0;

  logic [7:0] ebyte [16];
  string      etag  [16];
  bit         evld  [16];

  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", r, act, expv, pcnt);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && pcnt >= 5 && evld[(pcnt-5)%16])
      chk(vid_out == ebyte[(pcnt-5)%16], etag[(pcnt-5)%16],
          vid_out, ebyte[(pcnt-5)%16]);
  end

  // bench model of queued groups
  logic [7:0] mq[$];
  int         mlen[$];
  int         mavail[$];
  bit         mdef[$];
  bit         mcap[$];
  logic [7:0] cur[$];
  int wr_rem = 0, wr_sidx = 0, wr_k = 0, wr_gid = 0, wr_size = 0;
  bit wr_on = 0;

  function automatic bit closed_ln(input int ln, input bit s);
    if (s) return ln==5 || ln==6 || ln==7 || ln==318 || ln==319 || ln==320;
    return ln==9 || ln==10 || ln==11 || ln==272 || ln==273 || ln==274;
  endfunction

  task automatic run_line(input int ln, input bit s, input int seq);
    int g, ins_n;
    bit idef, icap, partial, have, blk, more;
    logic [7:0] ib [84];
    logic [7:0] v, e;
    string t;
    if (seq == 240) chk(ovf == 1'b0, "R5", ovf, 0);
    if (seq % 3 == 0 && wr_rem == 0) begin
      g = seq / 3;
      if (g % 7 == 3) begin wr_sidx = 110; wr_size = 40 + (g % 45); end
      else            begin wr_sidx = 20;  wr_size = (g % 90) + 1;  end
      wr_rem = wr_size; wr_on = 0; wr_k = 0; cur.delete();
    end
    partial = (wr_rem > 0) && wr_on;
    ins_n = 0; idef = 0; icap = 0;
    blk  = closed_ln(ln, s);
    have = (mlen.size() > 0) && (mavail[0] <= seq);
    if (have && !blk) begin
      ins_n = mlen[0]; idef = mdef[0]; icap = mcap[0];
      for (int k = 0; k < ins_n; k++) ib[k] = mq.pop_front();
      void'(mlen.pop_front()); void'(mavail.pop_front());
      void'(mdef.pop_front()); void'(mcap.pop_front());
    end else if (have && blk) begin
      mdef[0] = 1;
    end
    more = (mlen.size() > 0) && (mavail[0] <= seq);
    for (int i = 0; i < 124; i++) begin
      @(posedge clk); #1;
      vid_line = ln[9:0]; std625 = s;
      t = "R10";
      if (i == 0 || i == 104)      v = 8'hFF;
      else if (i < 3 || (i > 104 && i < 107)) v = 8'h00;
      else if (i == 3)             v = 8'hB6;
      else if (i == 107)           v = 8'hAB;
      else if (i >= 108)           v = 8'h40 | 8'(i & 63);
      else                         v = (i % 2 == 0) ? 8'h80 : 8'h10;
      e = v;
      if (i >= 4 && i < 104) begin
        if (i - 4 < ins_n) begin
          e = ib[i-4];
          if (i == 4)              t = "R2";
          else if (icap)           t = "R5";
          else if (idef)           t = "R8";
          else if (i - 4 == ins_n - 1) t = "R4";
          else                     t = "R3";
        end else if (partial)      t = "R9";
        else if (have && blk)      t = s ? "R7" : "R6";
        else if (ins_n > 0 && more) t = "R12";
        else if (ins_n > 0)        t = "R4";
        else                       t = "R1";
      end
      vid_in = v;
      if (wr_rem > 0 && (wr_on || i == wr_sidx)) begin
        wr_on = 1;
        q_data  = 8'((wr_gid * 13 + wr_k * 5 + 1) & 255);
        q_valid = 1; q_last = (wr_rem == 1);
        if (cur.size() < 84) cur.push_back(q_data);
        wr_k++; wr_rem--;
        if (wr_rem == 0) begin
          foreach (cur[k]) mq.push_back(cur[k]);
          mlen.push_back(cur.size()); mavail.push_back(seq + 1);
          mdef.push_back(0); mcap.push_back(wr_size > 84);
          wr_gid++; wr_on = 0;
        end
      end else begin
        q_valid = 0; q_last = 0; q_data = 8'h00;
      end
      ebyte[pcnt%16] = e; etag[pcnt%16] = t; evld[pcnt%16] = 1;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", pcnt);
    finish_run();
  end

  initial begin
    foreach (evld[k]) evld[k] = 0;
    rst = 1; vid_in = 0; vid_line = 0; std625 = 0;
    q_valid = 0; q_last = 0; q_data = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(vid_out == 8'h00, "R11", vid_out, 0);
    chk(ovf == 1'b0, "R11", ovf, 0);
    @(posedge clk); #1 rst = 0;
    for (int n = 0; n < 525; n++) run_line(n + 1, 1'b0, n);
    for (int n = 0; n < 625; n++) run_line(n + 1, 1'b1, 525 + n);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      vid_in = 8'h40; q_valid = 0; q_last = 0;
      evld[pcnt%16] = 0;
    end
    @(negedge clk);
    chk(ovf == 1'b1, "R5", ovf, 1);
    finish_run();
  end
endmodule